// File: doc/BRIEF.md
# AUX Request Bridge to Register Space and I2C

The block serves a DisplayPort-style auxiliary channel one request at a time. Each request carries a 4-bit command, a byte address, a byte count and a small data buffer. The block answers with a single 2-bit reply code and returns the buffer. Any bytes read during the request are written into the returned buffer. Native commands walk a 20-bit byte-addressed register space one byte per access through a request/done register port. I2C-over-AUX commands are turned into start, byte-write, byte-read and stop operations on an I2C controller port.

The bridge remembers whether an I2C transaction is still open. It also keeps the command and the 7-bit target of the last successful middle-of-transaction request. A later middle-of-transaction request with the same command and target continues on the open bus with no new start. A change of command, direction or target closes the bus and starts again. A plain I2C request always finishes with a stop.

Top module: `auxbr_top`

## Requirements
- R1: `req_ready` is high only while the bridge is idle. Each accepted request (`req_valid` with `req_ready`) produces exactly one single-cycle `rsp_valid` pulse. While the pulse is high, `req_ready` is low. After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Command bit 3 set selects a native access: 4'b1000 is a write and 4'b1001 is a read. Bit 3 clear selects I2C: bit 2 is the middle-of-transaction flag and bits 1:0 are 00 for write or 01 for read. Every other code gets reply NACK (2'd1) and causes no activity on either port. The other reply codes are ACK (2'd0) and I2C NACK (2'd2).
- R3: A native request issues one register access per byte, at the request address, then the address plus 1, and so on, wrapping at 2^20. A write sends buffer byte i (bits 8i+7:8i). A read stores each accepted byte into the same position of `rsp_data`. Bytes that were not read come back unchanged.
- R4: A native request stops at the first access with `reg_ok` low and replies NACK. Otherwise it replies ACK, including when the count is zero, which causes no access.
- R5: I2C operations use `i2c_op` codes START=0, WRITE=1, READ=2 and STOP=3. A START carries the target `req_addr[6:0]` on `i2c_addr` and the direction on `i2c_rd`. A plain I2C request first issues STOP if a transaction is open, then issues START.
- R6: A plain I2C request transfers its bytes in buffer order and always ends with STOP. It replies I2C NACK if any byte operation returns `i2c_ok` low, with no further bytes after the failure. Otherwise it replies ACK.
- R7: If a START returns `i2c_ok` low, no bytes are transferred. The bridge issues STOP, the transaction is closed and the reply is I2C NACK.
- R8: A middle-of-transaction request issues START when no transaction is open. When one is open with the same command and target as the last successful such request, it issues no START. On success it issues no STOP, leaves the transaction open and replies ACK.
- R9: A middle-of-transaction request that finds a transaction open with a different command or target issues STOP and then START before its bytes.
- R10: A failed byte in a middle-of-transaction request causes a STOP, closes the transaction and gives reply I2C NACK.
- R11: A byte count above the buffer size is treated as the buffer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, request accepted when valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Byte address or I2C target in bits 6:0 |
| req_len | input | LEN_W | Byte count |
| req_data | input | 8*NBYTES | Request buffer, byte i in bits 8i+7:8i |
| rsp_valid | output | 1 | Reply pulse |
| rsp_code | output | 2 | Reply code |
| rsp_data | output | 8*NBYTES | Returned buffer |
| reg_req | output | 1 | Register access pending, held until done |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | ADDR_W | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_done | input | 1 | Register access complete |
| reg_ok | input | 1 | Register access accepted |
| reg_rdata | input | 8 | Register read byte |
| i2c_op_valid | output | 1 | I2C operation pending, held until done |
| i2c_op | output | 2 | I2C operation code |
| i2c_rd | output | 1 | Direction for START |
| i2c_addr | output | 7 | Target for START |
| i2c_wdata | output | 8 | Byte for WRITE |
| i2c_done | input | 1 | I2C operation complete |
| i2c_ok | input | 1 | Operation acknowledged |
| i2c_rdata | input | 8 | Byte from READ |

## Verification
The bench builds the bridge with a 4-byte buffer and the 20-bit address space. Every byte count from zero up to full, plus one clamped count, fits in a short run. The sweep covers all four I2C command forms against a target that acknowledges everything, a target that acknowledges only its start, and one that acknowledges nothing. Running them back to back makes the middle-of-transaction continue, restart and close paths appear in many orders. A native run that starts near the top of the address space exercises the address wrap, and a rejected register makes a multi-byte read stop part way.

// File: rtl/auxbr_pkg.sv
package auxbr_pkg;

  typedef enum logic [1:0] {
    RSP_ACK      = 2'd0,
    RSP_NACK     = 2'd1,
    RSP_I2C_NACK = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  typedef enum logic [1:0] {
    K_BAD    = 2'd0,
    K_NATIVE = 2'd1,
    K_I2C    = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  rd;
    logic  mot;
  } cmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_NAT, S_PRESTOP, S_START, S_XFER, S_POSTSTOP, S_REPLY
  } seq_state_e;

endpackage

// File: rtl/auxbr_cmd_decode.sv
module auxbr_cmd_decode
  import auxbr_pkg::*;
(
  input  logic [3:0] cmd,
  output cmd_t       dec
);
  always_comb begin
    dec.rd   = cmd[0];
    dec.mot  = cmd[2];
    dec.kind = K_BAD;
    if (cmd[3]) begin
      if (cmd[2:1] == 2'b00) dec.kind = K_NATIVE;
    end else if (!cmd[1]) begin
      dec.kind = K_I2C;
    end
  end
endmodule

// File: rtl/auxbr_databuf.sv
module auxbr_databuf #(
  parameter int NBYTES = 16,
  parameter int LEN_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NBYTES*8-1:0] load_data,
  input  logic                wr,
  input  logic [LEN_W-1:0]    idx,
  input  logic [7:0]          wbyte,
  output logic [7:0]          rbyte,
  output logic [NBYTES*8-1:0] flat
);
  localparam int BI_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [7:0] mem_q [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic we_g;
    assign we_g = wr && (idx == LEN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (load) begin
        mem_q[g] <= load_data[8*g +: 8];
      end else if (we_g) begin
        mem_q[g] <= wbyte;
      end
    end

    assign flat[8*g +: 8] = mem_q[g];
  end

  assign rbyte = mem_q[idx[BI_W-1:0]];
endmodule

// File: rtl/auxbr_seq.sv
module auxbr_seq
  import auxbr_pkg::*;
#(
  parameter int NBYTES = 16,
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5,
  parameter int TA_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  cmd_t              dec,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              buf_load,
  output logic              buf_wr,
  output logic [LEN_W-1:0]  idx,
  output logic [7:0]        buf_wbyte,
  input  logic [7:0]        buf_rbyte,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_done,
  input  logic              reg_ok,
  input  logic [7:0]        reg_rdata,
  output logic              i2c_op_valid,
  output i2c_op_e           i2c_op,
  output logic              i2c_rd,
  output logic [TA_W-1:0]   i2c_addr,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_done,
  input  logic              i2c_ok,
  input  logic [7:0]        i2c_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code
);
  seq_state_e        state_q, state_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        code_q, code_d;
  logic              open_q, open_d;
  logic [3:0]        last_cmd_q, last_cmd_d;
  logic [TA_W-1:0]   last_ta_q, last_ta_d;
  cmd_t              cmd_q;
  logic [3:0]        raw_q;
  logic [LEN_W-1:0]  len_q, len_clamp;
  logic              cap_en, at_end, ta_change;

  assign len_clamp = (req_len > LEN_W'(NBYTES)) ? LEN_W'(NBYTES) : req_len;
  assign at_end    = (idx_q == len_q);
  assign ta_change = (req_cmd != last_cmd_q) || (req_addr[TA_W-1:0] != last_ta_q);

  // next-state logic
  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    addr_d     = addr_q;
    code_d     = code_q;
    open_d     = open_q;
    last_cmd_d = last_cmd_q;
    last_ta_d  = last_ta_q;
    cap_en     = 1'b0;
    buf_wr     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          idx_d  = '0;
          addr_d = req_addr;
          code_d = RSP_ACK;
          unique case (dec.kind)
            K_NATIVE: state_d = S_NAT;
            K_I2C: begin
              if (!dec.mot)      state_d = open_q ? S_PRESTOP : S_START;
              else if (!open_q)  state_d = S_START;
              else if (ta_change) state_d = S_PRESTOP;
              else               state_d = S_XFER;
            end
            default: begin
              code_d  = RSP_NACK;
              state_d = S_REPLY;
            end
          endcase
        end
      end
      S_NAT: begin
        if (at_end) begin
          state_d = S_REPLY;
        end else if (reg_done) begin
          if (reg_ok) begin
            buf_wr = cmd_q.rd;
            idx_d  = idx_q + LEN_W'(1);
            addr_d = addr_q + ADDR_W'(1);
          end else begin
            code_d  = RSP_NACK;
            state_d = S_REPLY;
          end
        end
      end
      S_PRESTOP: begin
        if (i2c_done) begin
          open_d  = 1'b0;
          state_d = S_START;
        end
      end
      S_START: begin
        if (i2c_done) begin
          if (i2c_ok) begin
            open_d  = 1'b1;
            state_d = S_XFER;
          end else begin
            code_d  = RSP_I2C_NACK;
            state_d = S_POSTSTOP;
          end
        end
      end
      S_XFER: begin
        if (at_end) begin
          if (cmd_q.mot) begin
            last_cmd_d = raw_q;
            last_ta_d  = addr_q[TA_W-1:0];
            state_d    = S_REPLY;
          end else begin
            state_d = S_POSTSTOP;
          end
        end else if (i2c_done) begin
          if (i2c_ok) begin
            buf_wr = cmd_q.rd;
            idx_d  = idx_q + LEN_W'(1);
          end else begin
            code_d  = RSP_I2C_NACK;
            state_d = S_POSTSTOP;
          end
        end
      end
      S_POSTSTOP: begin
        if (i2c_done) begin
          open_d  = 1'b0;
          state_d = S_REPLY;
        end
      end
      S_REPLY: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      addr_q     <= '0;
      code_q     <= '0;
      open_q     <= 1'b0;
      last_cmd_q <= '0;
      last_ta_q  <= '0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      addr_q     <= addr_d;
      code_q     <= code_d;
      open_q     <= open_d;
      last_cmd_q <= last_cmd_d;
      last_ta_q  <= last_ta_d;
    end
  end

  // request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      raw_q <= '0;
      len_q <= '0;
    end else if (cap_en) begin
      cmd_q <= dec;
      raw_q <= req_cmd;
      len_q <= len_clamp;
    end
  end

  // outputs
  always_comb begin
    unique case (state_q)
      S_START: i2c_op = OP_START;
      S_XFER:  i2c_op = cmd_q.rd ? OP_READ : OP_WRITE;
      default: i2c_op = OP_STOP;
    endcase
  end

  assign req_ready    = (state_q == S_IDLE);
  assign rsp_valid    = (state_q == S_REPLY);
  assign rsp_code     = code_q;
  assign reg_req      = (state_q == S_NAT) && !at_end;
  assign reg_we       = !cmd_q.rd;
  assign reg_addr     = addr_q;
  assign reg_wdata    = buf_rbyte;
  assign i2c_op_valid = (state_q == S_PRESTOP) || (state_q == S_START) ||
                        (state_q == S_POSTSTOP) || ((state_q == S_XFER) && !at_end);
  assign i2c_rd       = cmd_q.rd;
  assign i2c_addr     = addr_q[TA_W-1:0];
  assign i2c_wdata    = buf_rbyte;
  assign buf_wbyte    = (state_q == S_NAT) ? reg_rdata : i2c_rdata;
  assign buf_load     = cap_en;
  assign idx          = idx_q;
endmodule

// File: rtl/auxbr_top.sv
module auxbr_top
  import auxbr_pkg::*;
#(
  parameter  int NBYTES = 16,
  parameter  int ADDR_W = 20,
  localparam int LEN_W  = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_cmd,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [NBYTES*8-1:0] req_data,
  output logic                rsp_valid,
  output logic [1:0]          rsp_code,
  output logic [NBYTES*8-1:0] rsp_data,
  output logic                reg_req,
  output logic                reg_we,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [7:0]          reg_wdata,
  input  logic                reg_done,
  input  logic                reg_ok,
  input  logic [7:0]          reg_rdata,
  output logic                i2c_op_valid,
  output logic [1:0]          i2c_op,
  output logic                i2c_rd,
  output logic [6:0]          i2c_addr,
  output logic [7:0]          i2c_wdata,
  input  logic                i2c_done,
  input  logic                i2c_ok,
  input  logic [7:0]          i2c_rdata
);
  cmd_t             dec;
  logic             buf_load, buf_wr;
  logic [LEN_W-1:0] idx;
  logic [7:0]       buf_wbyte, buf_rbyte;
  i2c_op_e          op_e;

  auxbr_cmd_decode u_dec (
    .cmd (req_cmd),
    .dec (dec)
  );

  auxbr_databuf #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (buf_load),
    .load_data (req_data),
    .wr        (buf_wr),
    .idx       (idx),
    .wbyte     (buf_wbyte),
    .rbyte     (buf_rbyte),
    .flat      (rsp_data)
  );

  auxbr_seq #(.NBYTES(NBYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TA_W(7)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .dec          (dec),
    .req_cmd      (req_cmd),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .buf_load     (buf_load),
    .buf_wr       (buf_wr),
    .idx          (idx),
    .buf_wbyte    (buf_wbyte),
    .buf_rbyte    (buf_rbyte),
    .reg_req      (reg_req),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_done     (reg_done),
    .reg_ok       (reg_ok),
    .reg_rdata    (reg_rdata),
    .i2c_op_valid (i2c_op_valid),
    .i2c_op       (op_e),
    .i2c_rd       (i2c_rd),
    .i2c_addr     (i2c_addr),
    .i2c_wdata    (i2c_wdata),
    .i2c_done     (i2c_done),
    .i2c_ok       (i2c_ok),
    .i2c_rdata    (i2c_rdata),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code)
  );

  assign i2c_op = op_e;
endmodule

// File: rtl/auxbr_checker.sv
module auxbr_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_done,
  input logic              reg_ok,
  input logic              i2c_op_valid,
  input logic [1:0]        i2c_op,
  input logic [6:0]        i2c_addr,
  input logic              i2c_done
);
  a_r1_reply_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_busy_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r1_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && i2c_op_valid));

  a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'd3));

  a_r3_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_done) |=> (reg_req && $stable(reg_addr) && $stable(reg_we)));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_done && reg_ok) |=>
      (!reg_req || (reg_addr == ADDR_W'($past(reg_addr) + 1'b1))));

  a_r4_stop_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_done && !reg_ok) |=> !reg_req);

  a_r5_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_op_valid && !i2c_done) |=>
      (i2c_op_valid && $stable(i2c_op) && $stable(i2c_addr)));
endmodule

bind auxbr_top auxbr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_code     (rsp_code),
  .reg_req      (reg_req),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_done     (reg_done),
  .reg_ok       (reg_ok),
  .i2c_op_valid (i2c_op_valid),
  .i2c_op       (i2c_op),
  .i2c_addr     (i2c_addr),
  .i2c_done     (i2c_done)
);

// File: tb/auxbr_top_bench.sv
module auxbr_top_bench;
  localparam int NB  = 4;
  localparam int LW  = $clog2(NB + 1);
  localparam int AW  = 20;

  logic          clk, rst_n;
  logic          req_valid, req_ready;
  logic [3:0]    req_cmd;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [NB*8-1:0] req_data, rsp_data;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic          reg_req, reg_we, reg_done, reg_ok;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          i2c_op_valid, i2c_rd, i2c_done, i2c_ok;
  logic [1:0]    i2c_op;
  logic [6:0]    i2c_addr;
  logic [7:0]    i2c_wdata, i2c_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] got_log [64];
  logic [31:0] exp_log [64];
  int got_n, exp_n;

  // bench-side record of the bus and device state
  bit          e_open = 0;
  logic [3:0]  e_lcmd = '0;
  logic [6:0]  e_lta  = '0;
  int          e_rdcnt = 0;

  auxbr_top #(.NBYTES(NB), .ADDR_W(AW)) u_auxbr_top (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] mk(input logic [2:0] k, input logic b,
                                     input logic [19:0] a, input logic [7:0] d);
    return {k, b, a, d};
  endfunction

  function automatic logic [7:0] rv(input logic [19:0] a);
    return a[7:0] ^ a[19:12];
  endfunction

  // register space model
  bit rbusy = 0; int rcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_done <= 1'b0; reg_ok <= 1'b0; reg_rdata <= '0; rbusy = 0;
    end else if (reg_done) begin
      reg_done <= 1'b0;
    end else if (!rbusy && reg_req) begin
      rbusy = 1; rcnt = got_n % 3;
    end else if (rbusy) begin
      if (rcnt == 0) begin
        rbusy = 0;
        reg_done  <= 1'b1;
        reg_ok    <= (reg_addr[11:0] != 12'hFF0);
        reg_rdata <= rv(reg_addr);
        if (got_n < 64) got_log[got_n] = mk(3'd4, reg_we, reg_addr, reg_we ? reg_wdata : rv(reg_addr));
        got_n++;
      end else rcnt--;
    end
  end

  // I2C controller and devices: 0x50 acks all, 0x51 acks only its start
  bit ibusy = 0; int icnt = 0; logic [6:0] cur_ta = '0; int rdcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i2c_done <= 1'b0; i2c_ok <= 1'b0; i2c_rdata <= '0; ibusy = 0;
    end else if (i2c_done) begin
      i2c_done <= 1'b0;
    end else if (!ibusy && i2c_op_valid) begin
      ibusy = 1; icnt = (got_n + 1) % 3;
    end else if (ibusy) begin
      if (icnt == 0) begin
        ibusy = 0;
        i2c_done <= 1'b1;
        case (i2c_op)
          2'd0: begin
            cur_ta = i2c_addr;
            i2c_ok <= (i2c_addr == 7'h50) || (i2c_addr == 7'h51);
            if (got_n < 64) got_log[got_n] = mk(3'd0, i2c_rd, {13'd0, i2c_addr}, 8'd0);
          end
          2'd1: begin
            i2c_ok <= (cur_ta != 7'h51) && (i2c_wdata != 8'hEE);
            if (got_n < 64) got_log[got_n] = mk(3'd1, 1'b0, 20'd0, i2c_wdata);
          end
          2'd2: begin
            i2c_ok    <= (cur_ta != 7'h51);
            i2c_rdata <= 8'(8'h30 + rdcnt);
            if (got_n < 64) got_log[got_n] = mk(3'd2, 1'b0, 20'd0, 8'(8'h30 + rdcnt));
            rdcnt++;
          end
          default: begin
            i2c_ok <= 1'b1;
            if (got_n < 64) got_log[got_n] = mk(3'd3, 1'b0, 20'd0, 8'd0);
          end
        endcase
        got_n++;
      end else icnt--;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] e);
    if (exp_n < 64) exp_log[exp_n] = e;
    exp_n++;
  endtask

  // builds expected log/code/data from the requirements, drives, compares
  task automatic run_req(input string tag, input logic [3:0] cmd, input logic [19:0] addr,
                         input int len, input logic [NB*8-1:0] data);
    logic [1:0] ecode;
    logic [NB*8-1:0] edata;
    logic [19:0] a;
    logic [6:0] ta;
    bit rd, mot, fail, ok, start;
    int n, waitc, bad_at;
    edata = data; exp_n = 0; ecode = 2'd0;
    n = (len > NB) ? NB : len;
    rd = cmd[0]; mot = cmd[2]; ta = addr[6:0];
    if ((cmd[3] && cmd[2:1] != 2'b00) || (!cmd[3] && cmd[1])) begin
      ecode = 2'd1;
    end else if (cmd[3]) begin
      a = addr;
      for (int i = 0; i < n; i++) begin
        ok = (a[11:0] != 12'hFF0);
        push(mk(3'd4, !rd, a, rd ? rv(a) : data[8*i +: 8]));
        if (!ok) begin ecode = 2'd1; break; end
        if (rd) edata[8*i +: 8] = rv(a);
        a = a + 20'd1;
      end
    end else begin
      start = 1;
      if (!mot) begin
        if (e_open) push(mk(3'd3, 1'b0, 20'd0, 8'd0));
        e_open = 0;
      end else if (e_open) begin
        if (cmd != e_lcmd || ta != e_lta) begin
          push(mk(3'd3, 1'b0, 20'd0, 8'd0)); e_open = 0;
        end else start = 0;
      end
      fail = 0;
      if (start) begin
        push(mk(3'd0, rd, {13'd0, ta}, 8'd0));
        if (ta == 7'h50 || ta == 7'h51) e_open = 1; else fail = 1;
      end
      if (!fail) begin
        for (int i = 0; i < n; i++) begin
          if (rd) begin
            push(mk(3'd2, 1'b0, 20'd0, 8'(8'h30 + e_rdcnt)));
            ok = (ta != 7'h51);
            if (ok) edata[8*i +: 8] = 8'(8'h30 + e_rdcnt);
            e_rdcnt++;
          end else begin
            push(mk(3'd1, 1'b0, 20'd0, data[8*i +: 8]));
            ok = (ta != 7'h51) && (data[8*i +: 8] != 8'hEE);
          end
          if (!ok) begin fail = 1; break; end
        end
      end
      if (fail) begin
        ecode = 2'd2; push(mk(3'd3, 1'b0, 20'd0, 8'd0)); e_open = 0;
      end else if (!mot) begin
        push(mk(3'd3, 1'b0, 20'd0, 8'd0)); e_open = 0;
      end else begin
        e_lcmd = cmd; e_lta = ta;
      end
    end

    @(negedge clk);
    waitc = 0;
    while (!req_ready && waitc < 200) begin @(negedge clk); waitc++; end
    got_n = 0;
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LW'(len); req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!rsp_valid && waitc < 2000) begin
      chk(!req_ready, tag, "ready while busy R1", 64'(req_ready), 64'd0);
      @(negedge clk); waitc++;
    end
    chk(rsp_valid, tag, "reply arrived R1", 64'(rsp_valid), 64'd1);
    chk(rsp_code == ecode, tag, "reply code", 64'(rsp_code), 64'(ecode));
    chk(rsp_data == edata, tag, "returned data", 64'(rsp_data), 64'(edata));
    chk(got_n == exp_n, tag, "operation count", 64'(got_n), 64'(exp_n));
    bad_at = -1;
    for (int i = 0; i < exp_n && i < got_n && i < 64; i++)
      if (got_log[i] !== exp_log[i] && bad_at < 0) bad_at = i;
    chk(bad_at < 0, tag, "operation sequence",
        64'(bad_at < 0 ? 32'd0 : got_log[bad_at]), 64'(bad_at < 0 ? 32'd0 : exp_log[bad_at]));
    @(negedge clk);
    chk(!rsp_valid && req_ready, tag, "single reply pulse R1", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0; req_data = '0;
    got_n = 0; exp_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset", 64'({req_ready, rsp_valid}), 64'd2);

    // R2: every unused code
    for (int c = 0; c < 16; c++) begin
      if ((c[3] && c[2:1] != 2'b00) || (!c[3] && c[1]))
        run_req("R2", 4'(c), 20'h00050, 2, 32'h44332211);
    end

    // R3: native write across the top of the address space, then read
    run_req("R3", 4'b1000, 20'hFFFFE, 4, 32'hA4A3A2A1);
    run_req("R3", 4'b1001, 20'h12340, 3, 32'h55555555);
    // R4: rejected byte stops the read; zero count acks with no access
    run_req("R4", 4'b1001, 20'h00FEF, 4, 32'h66666666);
    run_req("R4", 4'b1000, 20'h00100, 0, 32'h0);
    // R11: oversize count clamps
    run_req("R11", 4'b1000, 20'h00200, 7, 32'h0D0C0B0A);

    // R8 continue, R9 restart, R5 plain closes open bus
    run_req("R8", 4'b0100, 20'h00050, 2, 32'h00002211);
    run_req("R8", 4'b0100, 20'h00050, 2, 32'h00004433);
    run_req("R9", 4'b0101, 20'h00050, 2, 32'h0);
    run_req("R9", 4'b0101, 20'h00051, 0, 32'h0);
    run_req("R5", 4'b0000, 20'h00050, 1, 32'h00000077);
    // R7 failed start; R6 failed write byte; R10 failed MOT byte
    run_req("R7", 4'b0001, 20'h00052, 3, 32'h99999999);
    run_req("R6", 4'b0000, 20'h00050, 4, 32'h44EE2211);
    run_req("R10", 4'b0100, 20'h00050, 3, 32'h00EE2211);
    run_req("R10", 4'b0101, 20'h00051, 2, 32'h0);

    // near-exhaustive sweep over I2C forms, targets and counts (R5 R6 R7 R8 R9 R10)
    k = 0;
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 3; t++) begin
        for (int l = 0; l <= NB; l++) begin
          run_req("R5 R6 R7 R8 R9 R10 sweep", {1'b0, f[1], 1'b0, f[0]},
                  20'(7'h50 + t), l, (k % 3 == 0) ? 32'h44EE2211 : 32'h44332211);
          k++;
          if (k % 4 == 1)
            run_req("R8 R9 sweep", {1'b0, 1'b1, 1'b0, f[0]}, 20'(7'h50 + t), 1, 32'h5A);
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule